// File: doc/BRIEF.md
# Serial Configuration Frame Engine

This block is a bit-serial master for a low-frequency receiver front-end. It drives an active-low chip select, a serial clock and a data line that can be turned around. The data line is split into an output value, an output enable and an input, so the pad or the testbench forms the tri-state line. A host makes a request with a one-cycle strobe that carries a request kind, a 16-bit word and a phase length. The engine reports `busy` while it works and a one-cycle `done` when it finishes.

There are three request kinds. A raw command sends the 16-bit word unchanged. A register write builds its own frame from an address and a data byte, adding a fixed write opcode and an odd parity bit. A read discards the device's leading bits, collects one data byte, and gives one more clock for the device's parity bit. Between transactions the data line is released, chip select is high and the clock rests low.

The controller has six states. IDLE accepts a request. PRE holds chip select high for one phase before a command or write. LOW sets up the data with the clock low. HIGH pulses the clock high. TAIL is a final low phase after the last pulse. FIN raises `done`. The transitions are IDLE→PRE (command or write accepted), IDLE→LOW (read accepted), PRE→LOW, LOW→HIGH, HIGH→LOW (more pulses due), HIGH→TAIL (last pulse), TAIL→FIN and FIN→IDLE. Every transition except those out of IDLE and FIN happens at the end of a phase.

Top module: `cfg_serial_master`

## Requirements
- R1: After reset and whenever idle: `cs_n`=1, `sclk`=0, `sdo_en`=0, `busy`=0, `done`=0.
- R2: `req_kind`=2'b01 (write) sends 16 bits MSB first: 3'b111, then address `req_word[11:8]`, then data `req_word[7:0]`, then a parity bit.
- R3: The write parity bit makes the 8 data bits plus parity hold an odd number of ones.
- R4: `req_kind`=2'b00 (command) sends `req_word[15:0]` as 16 bits, MSB first.
- R5: For a command or a write, `cs_n` stays high for one phase after acceptance, then goes low before the first clock. `cs_n` is low at every rising edge of `sclk`, and `sdo` changes only while `sclk` is low.
- R6: Every high and low phase of `sclk` lasts `phase_len`+1 system clocks. With P = `phase_len`+1, `busy` is high for 34·P+1 cycles on a command or write and 33·P+1 cycles on a read.
- R7: `req_kind`=2'b10 (read) gives 16 clock pulses with `sdo_en` low throughout. `sdi` is sampled right after the falling edges of pulses 8 to 15, MSB first, and the result is on `rd_data`. The first 7 pulses and pulse 16 capture nothing.
- R8: `done` is high for exactly one cycle at the end of each transaction. In that cycle `cs_n`=1 and `sdo_en`=0.
- R9: A request made while `busy` is high is ignored. The frame in progress and its timing are unchanged, and no second transaction follows.
- R10: `req_kind`=2'b11 starts no transaction. `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_kind | input | 2 | 00 command, 01 write, 10 read, 11 none |
| req_word | input | 16 | Command word, or address [11:8] and data [7:0] |
| phase_len | input | DIV_W | Phase length minus one, in system clocks |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 8 | Byte captured by the last read |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out value |
| sdo_en | output | 1 | Serial data output enable |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the engine with `DIV_W`=2, so the phase length runs through its whole range of 1 to 4 clocks, and every cycle count of R6 is checked at each setting. At that size all 16 addresses can be tried at every phase length. All 256 data bytes go through both the write path (parity) and the read path (capture), and a device model drives junk on `sdi` outside the capture window. The bench injects requests in the middle of writes and reads, and sends the unused kind, to show that the block ignores them.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

    typedef enum logic [1:0] {
        KIND_CMD  = 2'b00,
        KIND_WR   = 2'b01,
        KIND_RD   = 2'b10,
        KIND_NONE = 2'b11
    } req_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_FIN
    } fsm_state_t;

endpackage

// File: rtl/cfg_phase_timer.sv
module cfg_phase_timer #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] len,
    output logic             phase_end,
    output logic             phase_start
);

    logic [DIV_W-1:0] cnt_q;

    assign phase_end   = run && (cnt_q == len);
    assign phase_start = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_frame_build.sv
module cfg_frame_build
    import cfg_serial_pkg::*;
#(
    parameter int OPC_W   = 3,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int FRAME_W = OPC_W + ADDR_W + DATA_W + 1
) (
    input  req_kind_t          kind,
    input  logic [FRAME_W-1:0] word,
    output logic [FRAME_W-1:0] frame
);

    localparam logic [OPC_W-1:0] WR_OPC = '1;

    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              odd_par;

    assign addr    = word[DATA_W +: ADDR_W];
    assign data    = word[DATA_W-1:0];
    assign odd_par = ~(^data);

    always_comb begin
        if (kind == KIND_WR) begin
            frame = {WR_OPC, addr, data, odd_par};
        end else begin
            frame = word;
        end
    end

endmodule

// File: rtl/cfg_rx_shift.sv
module cfg_rx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              din,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clear) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[DATA_W-2:0], din};
        end
    end

endmodule

// File: rtl/cfg_serial_master.sv
module cfg_serial_master
    import cfg_serial_pkg::*;
#(
    parameter int DIV_W   = 4,
    parameter int OPC_W   = 3,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int RD_SKIP = 7,
    localparam int FRAME_W = OPC_W + ADDR_W + DATA_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [FRAME_W-1:0] req_word,
    input  logic [DIV_W-1:0]   phase_len,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic               cs_n,
    output logic               sclk,
    output logic               sdo,
    output logic               sdo_en,
    input  logic               sdi
);

    localparam int RD_PULSES = RD_SKIP + DATA_W + 1;
    localparam int MAX_PULSE = (RD_PULSES > FRAME_W) ? RD_PULSES : FRAME_W;
    localparam int IDX_W     = $clog2(MAX_PULSE + 1);
    localparam logic [IDX_W-1:0] CAP_LO = IDX_W'(RD_SKIP + 1);
    localparam logic [IDX_W-1:0] CAP_HI = IDX_W'(RD_SKIP + DATA_W);

    fsm_state_t         state_q, state_d;
    req_kind_t          kind_q;
    req_kind_t          kind_in;
    logic [DIV_W-1:0]   len_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0]   idx_q;
    logic [IDX_W-1:0]   npulse;
    logic               accept;
    logic               timer_run;
    logic               pe;
    logic               ps;
    logic               last_pulse;
    logic               cap_en;

    assign kind_in    = req_kind_t'(req_kind);
    assign accept     = (state_q == ST_IDLE) && req_valid && (kind_in != KIND_NONE);
    assign timer_run  = (state_q == ST_PRE) || (state_q == ST_LOW) ||
                        (state_q == ST_HIGH) || (state_q == ST_TAIL);
    assign npulse     = (kind_q == KIND_RD) ? IDX_W'(RD_PULSES) : IDX_W'(FRAME_W);
    assign last_pulse = (idx_q == npulse - IDX_W'(1));
    assign cap_en     = ((state_q == ST_LOW) || (state_q == ST_TAIL)) && ps &&
                        (kind_q == KIND_RD) && (idx_q >= CAP_LO) && (idx_q <= CAP_HI);

    cfg_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (timer_run),
        .len         (len_q),
        .phase_end   (pe),
        .phase_start (ps)
    );

    cfg_frame_build #(
        .OPC_W   (OPC_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W)
    ) u_build (
        .kind  (kind_in),
        .word  (req_word),
        .frame (frame)
    );

    cfg_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .shift_en (cap_en),
        .din      (sdi),
        .q        (rd_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = (kind_in == KIND_RD) ? ST_LOW : ST_PRE;
            ST_PRE:  if (pe) state_d = ST_LOW;
            ST_LOW:  if (pe) state_d = ST_HIGH;
            ST_HIGH: if (pe) state_d = last_pulse ? ST_TAIL : ST_LOW;
            ST_TAIL: if (pe) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_NONE;
            len_q   <= '0;
            shreg_q <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q  <= kind_in;
                len_q   <= phase_len;
                shreg_q <= frame;
                idx_q   <= '0;
            end else if ((state_q == ST_HIGH) && pe) begin
                shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                idx_q   <= idx_q + IDX_W'(1);
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy   = 1'b1;
        done   = 1'b0;
        cs_n   = 1'b0;
        sclk   = 1'b0;
        sdo_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                cs_n = 1'b1;
            end
            ST_PRE:  cs_n = 1'b1;
            ST_LOW:  sdo_en = (kind_q != KIND_RD);
            ST_HIGH: begin
                sclk   = 1'b1;
                sdo_en = (kind_q != KIND_RD);
            end
            ST_TAIL: cs_n = 1'b0;
            ST_FIN: begin
                done = 1'b1;
                cs_n = 1'b1;
            end
            default: cs_n = 1'b1;
        endcase
        sdo = sdo_en & shreg_q[FRAME_W-1];
    end

endmodule

// File: rtl/cfg_serial_master_chk.sv
module cfg_serial_master_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic cs_n,
    input logic sclk,
    input logic sdo,
    input logic sdo_en
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk && !sdo_en && !done));

    p_cs_low_on_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    p_sdo_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !sdo_en && busy));

    p_busy_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && req_valid) |=> busy);

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind cfg_serial_master cfg_serial_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdo       (sdo),
    .sdo_en    (sdo_en)
);

// File: tb/cfg_serial_master_test.sv
`timescale 1ns/1ps
module cfg_serial_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_word = '0;
    logic [1:0]  phase_len = '0;
    logic        busy, done, cs_n, sclk, sdo, sdo_en;
    logic [7:0]  rd_data;
    logic        sdi = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // observation results of one transaction
    logic [15:0] got;
    int cyc, pre_hi, nrise, stab_bad, done_cnt, cs_bad, done_bad, en_seen;

    always #2.5 clk = ~clk;

    cfg_serial_master #(.DIV_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_word(req_word), .phase_len(phase_len), .busy(busy), .done(done),
        .rd_data(rd_data), .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .sdo_en(sdo_en),
        .sdi(sdi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one transaction and records what the serial pins did.
    task automatic run_txn(input logic [1:0] k, input logic [15:0] w,
                           input logic [1:0] pl, input logic [7:0] rd_byte,
                           input bit inject);
        logic prev_sclk;
        logic prev_sdo;
        int falls;
        got = '0; cyc = 0; pre_hi = 0; nrise = 0; stab_bad = 0;
        done_cnt = 0; cs_bad = 0; done_bad = 0; en_seen = 0;
        falls = 0; prev_sclk = 1'b0; prev_sdo = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_word = w; phase_len = pl;
        @(negedge clk);
        req_valid = 1'b0;
        phase_len = ~pl;
        while (busy && cyc < 2000) begin
            cyc++;
            if (done) begin
                done_cnt++;
                if (!cs_n || sdo_en) done_bad++;
            end
            if (sclk && !prev_sclk) begin
                got = {got[14:0], sdo};
                nrise++;
                if (cs_n) cs_bad++;
            end
            if (sclk && prev_sclk && (sdo != prev_sdo)) stab_bad++;
            if (nrise == 0 && cs_n) pre_hi++;
            if (sdo_en) en_seen++;
            if (!sclk && prev_sclk) falls++;
            if (falls >= 8 && falls <= 15) sdi = rd_byte[15 - falls];
            else sdi = ~rd_byte[falls % 8];
            if (inject && cyc == 5) begin
                req_valid = 1'b1; req_kind = 2'b10; req_word = ~w;
            end
            if (inject && cyc == 6) req_valid = 1'b0;
            prev_sclk = sclk;
            prev_sdo = sdo;
            @(negedge clk);
        end
        sdi = 1'b0;
    endtask

    function automatic logic [15:0] wr_frame(input logic [3:0] a, input logic [7:0] d);
        logic p;
        p = ($countones(d) % 2 == 0);
        return {3'b111, a, d, p};
    endfunction

    task automatic check_write(input logic [3:0] a, input logic [7:0] d,
                               input logic [1:0] pl, input bit inject);
        logic [15:0] exp;
        int p;
        exp = wr_frame(a, d);
        p = int'(pl) + 1;
        run_txn(2'b01, {4'h0, a, d}, pl, 8'h00, inject);
        chk(got[15:13] == 3'b111 && got[12:1] == exp[12:1], "R2 write frame", got, exp);
        chk(($countones(got[8:0]) % 2) == 1, "R3 odd parity", got[0], exp[0]);
        chk(cyc == 34 * p + 1, "R6 write busy cycles", cyc, 34 * p + 1);
        chk(pre_hi == p && cs_bad == 0 && stab_bad == 0, "R5 select and setup", pre_hi, p);
        chk(done_cnt == 1 && done_bad == 0, "R8 done pulse", done_cnt, 1);
        chk(nrise == 16, "R6 pulse count", nrise, 16);
        if (inject) begin
            chk(got == exp, "R9 injected write unchanged", got, exp);
            @(negedge clk);
            chk(!busy, "R9 no follow-on transaction", busy, 0);
        end
    endtask

    task automatic check_cmd(input logic [15:0] w, input logic [1:0] pl);
        int p;
        p = int'(pl) + 1;
        run_txn(2'b00, w, pl, 8'h00, 1'b0);
        chk(got == w, "R4 command word", got, w);
        chk(cyc == 34 * p + 1, "R6 command busy cycles", cyc, 34 * p + 1);
        chk(pre_hi == p && cs_bad == 0 && stab_bad == 0, "R5 command select", pre_hi, p);
    endtask

    task automatic check_read(input logic [7:0] b, input logic [1:0] pl, input bit inject);
        int p;
        p = int'(pl) + 1;
        run_txn(2'b10, 16'hFFFF, pl, b, inject);
        chk(rd_data == b, "R7 read byte", rd_data, b);
        chk(en_seen == 0 && nrise == 16, "R7 no drive, 16 pulses", en_seen, 0);
        chk(cyc == 33 * p + 1, "R6 read busy cycles", cyc, 33 * p + 1);
        chk(done_cnt == 1 && done_bad == 0 && pre_hi == 0, "R8 read done", done_cnt, 1);
        if (inject) begin
            @(negedge clk);
            chk(!busy, "R9 read not restarted", busy, 0);
        end
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && !sclk && !sdo_en && !busy && !done, "R1 reset state",
            {cs_n, sclk, sdo_en, busy, done}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !sclk && !sdo_en && !busy && !done, "R1 idle after reset",
            {cs_n, sclk, sdo_en, busy, done}, 5'b10000);

        for (int pl = 0; pl < 4; pl++) begin
            for (int a = 0; a < 16; a++) begin
                check_write(4'(a), 8'((a * 37 + pl * 91) & 8'hFF), 2'(pl), 1'b0);
            end
            check_cmd(16'hA000, 2'(pl));
            check_cmd(16'h2000, 2'(pl));
            check_cmd(16'h5A3C ^ 16'(pl * 4097), 2'(pl));
            check_read(8'(8'hC5 + pl), 2'(pl), 1'b0);
        end
        for (int d = 0; d < 256; d++) begin
            check_write(4'(d % 16), 8'(d), 2'd0, 1'b0);
            check_read(8'(d), 2'd0, 1'b0);
        end
        check_write(4'h6, 8'h9F, 2'd2, 1'b1);
        check_read(8'h81, 2'd1, 1'b1);

        // unused kind: nothing starts
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b11; req_word = 16'h1234; phase_len = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!busy && cs_n, "R10 unused kind idle", busy, 0);
        repeat (3) @(negedge clk);
        chk(!busy && !done && cs_n && !sclk, "R10 stays idle", busy, 0);
        chk(!sdo_en, "R1 idle released", sdo_en, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule